// File: doc/BRIEF.md
# Timestamped Input Transition Capture

This block watches a bank of digital input lines and logs every qualifying edge together with the value of an external free-running I/O timer. Each line can be armed separately for rising edges, falling edges, both or neither. All qualifying edges seen in one clock cycle are merged into one record. The record holds a bitmap of the lines that fired and the timer value from that cycle. Records queue in a small FIFO. The oldest record is always presented on the read port, where software or a downstream engine takes it.

The read side is a valid/ready stream. `rd_valid` high means at least one record is queued, so it also serves as the data-available flag. A record leaves only on a cycle where `rd_valid` and `rd_ready` are both high. While `rd_valid` is high and `rd_ready` is low, `rd_data` holds its value. Ready asserted while valid is low has no effect. The capture side has no back-pressure: an edge that finds the queue full is lost. That loss latches a sticky overflow flag, which the status-read strobe clears.

An interrupt pulse can be enabled for two causes: a record written into an empty queue, or a write that leaves the queue full, so that the next record would overflow it. The timer is an input and is advanced outside the block. In the intended system it ticks once per twelve state times.

Top module: `edge_stamp_capture`

## Requirements
- R1: While reset is active and directly after it, `rd_valid`, `ovf_flag` and `irq` are all low.
- R2: An edge on line i, where that line's polarity is enabled (`rise_en[i]` for 0→1, `fall_en[i]` for 1→0), produces one record. In that record `rd_data[16+i]` is set and `rd_data[15:0]` equals `timer` in the cycle the record is written.
- R3: An edge whose polarity is not enabled for its line produces no record and leaves the queue unchanged.
- R4: Qualifying edges on several lines in the same cycle produce a single record with all of their bits set in `rd_data[23:16]`.
- R5: A change on `lines_in` set up before clock edge k becomes visible on the read port (`rd_valid` high, record present) after edge k+2. It is not visible after edge k+1.
- R6: Records leave in arrival order, one per cycle with `rd_valid && rd_ready`. `rd_data` holds while `rd_valid` is high and the record is not taken. A take attempted while empty has no effect.
- R7: The queue holds DEPTH (default 11) records. A record arriving when the queue is full and no take happens in that cycle is discarded, the stored records are unchanged, and `ovf_flag` goes high.
- R8: `ovf_flag` stays high until a cycle with `stat_rd` high, and is low after that cycle.
- R9: With `irq_first_en` high, a write into an empty queue gives a one-cycle `irq` pulse, in the same cycle that `rd_valid` rises. With it low, no pulse is given for that cause.
- R10: With `irq_full_en` high, a write that brings the queue to DEPTH records gives exactly one one-cycle `irq` pulse.
- R11: A record arriving when the queue is full, in the same cycle as a take, is stored, and `ovf_flag` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lines_in | input | 8 | Asynchronous input lines being monitored |
| rise_en | input | 8 | Per-line enable for rising-edge capture |
| fall_en | input | 8 | Per-line enable for falling-edge capture |
| timer | input | 16 | Free-running I/O timer value used as the timestamp |
| irq_first_en | input | 1 | Enable interrupt on a write into an empty queue |
| irq_full_en | input | 1 | Enable interrupt when the queue becomes full |
| stat_rd | input | 1 | Status-read strobe; clears the overflow flag |
| rd_valid | output | 1 | Record available (data-available flag) |
| rd_ready | input | 1 | Take the presented record |
| rd_data | output | 24 | Oldest record: {line bitmap, timestamp} |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions check the following on every cycle:
- the queue occupancy never exceeds its depth;
- a presented record holds until it is taken;
- a take from an empty queue changes nothing;
- a record arriving at a full queue is dropped and raises the overflow flag;
- the overflow flag stays set until a status read;
- every interrupt pulse follows an accepted write.

Only the bench's scenarios can show the rest:
- the per-line polarity selection;
- the bitmap positions and the timestamp values;
- the merging of simultaneous edges;
- the two-stage synchroniser latency;
- the arrival order of records after a full fill and drain;
- the full-queue write paired with a take.

// File: rtl/esc_pkg.sv
package esc_pkg;
  localparam int unsigned ESC_LINES = 8;
  localparam int unsigned ESC_TS_W  = 16;
  localparam int unsigned ESC_DEPTH = 11;

  // Occupancy change selected by accepted write/take pair
  typedef enum logic [1:0] {
    OCC_HOLD = 2'b00,
    OCC_DEC  = 2'b01,
    OCC_INC  = 2'b10,
    OCC_SWAP = 2'b11
  } occ_op_e;
endpackage

// File: rtl/esc_edge_detect.sv
module esc_edge_detect #(
  parameter int unsigned LINES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] lines_in,
  input  logic [LINES-1:0] rise_en,
  input  logic [LINES-1:0] fall_en,
  output logic             ev_hit,
  output logic [LINES-1:0] ev_map
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic meta_q, sync_q, prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= lines_in[i];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end
    assign ev_map[i] = (sync_q & ~prev_q & rise_en[i]) |
                       (~sync_q & prev_q & fall_en[i]);
  end

  assign ev_hit = |ev_map;
endmodule

// File: rtl/esc_fifo.sv
module esc_fifo
  import esc_pkg::*;
#(
  parameter int unsigned W     = 24,
  parameter int unsigned DEPTH = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_req,
  input  logic [W-1:0] wr_data,
  input  logic         rd_req,
  output logic         wr_acc,
  output logic         rd_acc,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full,
  output logic         almost_full
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  occ_op_e       op;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign empty       = (count == '0);
  assign full        = (count == CW'(DEPTH));
  assign almost_full = (count == CW'(DEPTH - 1));
  assign rd_acc      = rd_req && !empty;
  assign wr_acc      = wr_req && (!full || rd_acc);
  assign head        = mem[rd_ptr];
  assign op          = occ_op_e'({wr_acc, rd_acc});

  always_ff @(posedge clk) begin
    if (wr_acc) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_acc) wr_ptr <= bump(wr_ptr);
      if (rd_acc) rd_ptr <= bump(rd_ptr);
      case (op)
        OCC_INC: count <= count + 1'b1;
        OCC_DEC: count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R6: occupancy never exceeds the depth
  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R6: a presented record holds until taken
  p_head_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && !rd_req) |=> (!empty && $stable(head)));

  // R6: a take from an empty queue changes nothing
  p_empty_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_req && !wr_req) |=> empty);

  // R7: a record arriving at a full queue without a take is dropped
  p_drop_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_req && !rd_req) |=> (full && $stable(wr_ptr)));
endmodule

// File: rtl/esc_ctrl.sv
module esc_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_req,
  input  logic wr_acc,
  input  logic rd_acc,
  input  logic was_empty,
  input  logic near_full,
  input  logic irq_first_en,
  input  logic irq_full_en,
  input  logic stat_rd,
  output logic ovf_flag,
  output logic irq
);
  logic drop, first_hit, fill_hit;

  assign drop      = wr_req && !wr_acc;
  assign first_hit = irq_first_en && wr_acc && was_empty;
  assign fill_hit  = irq_full_en && wr_acc && !rd_acc && near_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (drop)         ovf_flag <= 1'b1;
      else if (stat_rd) ovf_flag <= 1'b0;
      irq <= first_hit || fill_hit;
    end
  end

  // R8: overflow flag is sticky until a status read
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !stat_rd) |=> ovf_flag);

  // R7: a dropped record raises the overflow flag
  p_ovf_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> ovf_flag);

  // R9: every interrupt pulse follows an accepted write
  p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(wr_acc));
endmodule

// File: rtl/edge_stamp_capture.sv
module edge_stamp_capture
  import esc_pkg::*;
#(
  parameter int unsigned LINES = ESC_LINES,
  parameter int unsigned TS_W  = ESC_TS_W,
  parameter int unsigned DEPTH = ESC_DEPTH
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LINES-1:0]      lines_in,
  input  logic [LINES-1:0]      rise_en,
  input  logic [LINES-1:0]      fall_en,
  input  logic [TS_W-1:0]       timer,
  input  logic                  irq_first_en,
  input  logic                  irq_full_en,
  input  logic                  stat_rd,
  output logic                  rd_valid,
  input  logic                  rd_ready,
  output logic [LINES+TS_W-1:0] rd_data,
  output logic                  ovf_flag,
  output logic                  irq
);
  localparam int unsigned W = LINES + TS_W;

  logic             ev_hit;
  logic [LINES-1:0] ev_map;
  logic             wr_acc, rd_acc, empty, full, almost_full;

  esc_edge_detect #(.LINES(LINES)) u_edge (
    .clk(clk), .rst_n(rst_n), .lines_in(lines_in),
    .rise_en(rise_en), .fall_en(fall_en),
    .ev_hit(ev_hit), .ev_map(ev_map)
  );

  esc_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .wr_req(ev_hit), .wr_data({ev_map, timer}),
    .rd_req(rd_ready), .wr_acc(wr_acc), .rd_acc(rd_acc),
    .head(rd_data), .empty(empty), .full(full), .almost_full(almost_full)
  );

  esc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wr_req(ev_hit), .wr_acc(wr_acc), .rd_acc(rd_acc),
    .was_empty(empty), .near_full(almost_full),
    .irq_first_en(irq_first_en), .irq_full_en(irq_full_en),
    .stat_rd(stat_rd), .ovf_flag(ovf_flag), .irq(irq)
  );

  assign rd_valid = !empty;

  // R11: a full-queue write paired with a take raises no overflow
  p_swap_no_ovf_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (full && ev_hit && rd_ready && !ovf_flag && !stat_rd) |=> !ovf_flag);
endmodule

// File: tb/edge_stamp_capture_bench.sv
module edge_stamp_capture_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  lines_in = '0, rise_en = '0, fall_en = '0;
  logic [15:0] timer = '0;
  logic        irq_first_en = 1'b0, irq_full_en = 1'b0, stat_rd = 1'b0;
  logic        rd_ready = 1'b0;
  logic        rd_valid, ovf_flag, irq;
  logic [23:0] rd_data;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  edge_stamp_capture u_edge_stamp_capture (
    .clk(clk), .rst_n(rst_n), .lines_in(lines_in), .rise_en(rise_en),
    .fall_en(fall_en), .timer(timer), .irq_first_en(irq_first_en),
    .irq_full_en(irq_full_en), .stat_rd(stat_rd), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .ovf_flag(ovf_flag), .irq(irq)
  );

  // {rise_en, fall_en, lines, timer, expected bitmap}
  localparam logic [47:0] VEC [9] = '{
    {8'hFF, 8'h00, 8'h01, 16'h1111, 8'h01},
    {8'hFF, 8'h00, 8'h00, 16'h1212, 8'h00},
    {8'h00, 8'hFF, 8'h80, 16'h1313, 8'h00},
    {8'h00, 8'hFF, 8'h00, 16'h2222, 8'h80},
    {8'hFF, 8'hFF, 8'h0F, 16'h3333, 8'h0F},
    {8'h0F, 8'h0F, 8'hF0, 16'h4444, 8'h0F},
    {8'hF0, 8'h00, 8'h00, 16'h4545, 8'h00},
    {8'hAA, 8'h55, 8'hFF, 16'h5555, 8'hAA},
    {8'h00, 8'h55, 8'h00, 16'h6666, 8'h55}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic take();
    @(negedge clk) rd_ready = 1'b1;
    @(negedge clk) rd_ready = 1'b0;
  endtask

  // toggle line 0 and wait until the record is written; returns irq pulses seen
  task automatic toggle(input logic [15:0] t, output int pulses);
    pulses = 0;
    @(negedge clk);
    timer = t;
    lines_in[0] = ~lines_in[0];
    repeat (3) begin
      @(negedge clk);
      if (irq) pulses++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int p, tot;
    repeat (3) @(negedge clk);
    chk(!rd_valid && !ovf_flag && !irq, "R1 in reset", {rd_valid, ovf_flag, irq}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rd_valid && !ovf_flag && !irq, "R1 after reset", {rd_valid, ovf_flag, irq}, 0);

    // table walk: polarity selection, bitmap and stamp, merging
    for (int v = 0; v < 9; v++) begin
      @(negedge clk);
      rise_en  = VEC[v][47:40];
      fall_en  = VEC[v][39:32];
      lines_in = VEC[v][31:24];
      timer    = VEC[v][23:8];
      repeat (4) @(negedge clk);
      if (VEC[v][7:0] == 8'h00) begin
        chk(!rd_valid, "R3 disabled edge ignored", rd_valid, 0);
      end else begin
        chk(rd_valid, ($countones(VEC[v][7:0]) > 1) ? "R4 merged valid" : "R2 valid",
            rd_valid, 1);
        chk(rd_data == {VEC[v][7:0], VEC[v][23:8]},
            ($countones(VEC[v][7:0]) > 1) ? "R4 merged record" : "R2 record",
            rd_data, {VEC[v][7:0], VEC[v][23:8]});
        take();
        chk(!rd_valid, "R6 drained after take", rd_valid, 0);
      end
    end

    // R5 latency and R9 first-entry interrupt
    irq_first_en = 1'b1;
    rise_en = 8'hFF;
    fall_en = 8'hFF;
    @(negedge clk);
    timer = 16'h5A5A;
    lines_in = 8'h10;
    @(negedge clk);
    chk(!rd_valid, "R5 not visible after one edge", rd_valid, 0);
    @(negedge clk);
    chk(!rd_valid, "R5 not visible after two edges", rd_valid, 0);
    chk(!irq, "R9 no early pulse", irq, 0);
    @(negedge clk);
    chk(rd_valid, "R5 visible after three edges", rd_valid, 1);
    chk(rd_data == {8'h10, 16'h5A5A}, "R5 record", rd_data, {8'h10, 16'h5A5A});
    chk(irq, "R9 pulse with first entry", irq, 1);
    @(negedge clk);
    chk(!irq, "R9 pulse one cycle", irq, 0);
    take();
    irq_first_en = 1'b0;
    toggle(16'h0BAD, p);
    lines_in[4] = 1'b0;
    repeat (4) @(negedge clk);
    chk(p == 0, "R9 no pulse when disabled", p, 0);
    take();
    take();
    chk(!rd_valid, "R6 queue empty", rd_valid, 0);

    // fill to full with full interrupt enabled
    irq_full_en = 1'b1;
    tot = 0;
    for (int k = 0; k < 11; k++) begin
      toggle(16'(100 + k), p);
      tot += p;
      if (k == 10) chk(p == 1, "R10 pulse on filling write", p, 1);
    end
    toggle(16'd999, p);
    tot += p;
    chk(tot == 1, "R10 exactly one pulse", tot, 1);
    chk(ovf_flag, "R7 overflow set", ovf_flag, 1);
    repeat (3) @(negedge clk);
    chk(ovf_flag, "R8 overflow sticky", ovf_flag, 1);
    @(negedge clk) stat_rd = 1'b1;
    @(negedge clk) stat_rd = 1'b0;
    chk(!ovf_flag, "R8 cleared by status read", ovf_flag, 0);
    for (int k = 0; k < 11; k++) begin
      chk(rd_valid && rd_data == {8'h01, 16'(100 + k)}, "R6 order after fill",
          rd_data, {8'h01, 16'(100 + k)});
      take();
    end
    chk(!rd_valid, "R7 dropped record absent", rd_valid, 0);

    // take on empty has no effect
    @(negedge clk) rd_ready = 1'b1;
    repeat (2) @(negedge clk);
    rd_ready = 1'b0;
    chk(!rd_valid, "R6 take on empty", rd_valid, 0);
    toggle(16'd777, p);
    chk(rd_valid && rd_data == {8'h01, 16'd777}, "R6 no underflow", rd_data,
        {8'h01, 16'd777});
    take();
    chk(!rd_valid, "R6 empty again", rd_valid, 0);

    // full queue: write paired with a take
    irq_full_en = 1'b0;
    for (int k = 0; k < 11; k++) toggle(16'(200 + k), p);
    @(negedge clk);
    timer = 16'd888;
    lines_in[0] = ~lines_in[0];
    @(negedge clk);
    @(negedge clk) rd_ready = 1'b1;
    @(negedge clk) rd_ready = 1'b0;
    chk(!ovf_flag, "R11 no overflow on paired write", ovf_flag, 0);
    for (int k = 1; k < 11; k++) begin
      chk(rd_data == {8'h01, 16'(200 + k)}, "R11 order kept", rd_data,
          {8'h01, 16'(200 + k)});
      take();
    end
    chk(rd_valid && rd_data == {8'h01, 16'd888}, "R11 paired record stored", rd_data,
        {8'h01, 16'd888});
    take();
    chk(!rd_valid, "R11 drained", rd_valid, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule